// File: doc/BRIEF.md
# Small-Page NAND Command Sequencer

This block turns one command request into the stream of byte cycles that a 512-byte-page NAND device expects on its shared I/O bus. A request carries an opcode, an optional column, an optional page address and a presence flag for each of the two addresses. The sequencer walks through a fixed order of steps and emits each byte with its latch flags: command cycles raise the command-latch flag and address cycles raise the address-latch flag. The last cycle of every sequence releases chip enable.

Small-page devices select the page region with a pointer read opcode rather than with column bits. For a data-input request, the block therefore first sends the pointer opcode that the column calls for and rebases the column into that region. It then sends the data-input opcode and the address bytes. The column is halved on a 16-bit bus, except for opcodes that always use 8-bit addressing. After the sequence ends, the block decides whether the ready/busy wait engine must run, and signals this with a one-cycle trigger.

The request side is a valid/ready handshake and accepts a new request only when the sequencer is idle. The cycle stream is a valid/ready stream that holds each byte until the downstream stage takes it. Data transfer cycles and electrical timing belong to other blocks.

Top module: `spnand_cmd_seq`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `cyc_valid_o` and `wait_start_o` are 0.
- R2: Every sequence runs in this order: optional pointer command, the request opcode, optional column, optional row cycles, then a release cycle. Command cycles carry CLE=1, ALE=0, CE=1. Address cycles carry CLE=0, ALE=1, CE=1. The release cycle carries CLE=0, ALE=0, CE=0 and byte 0x00.
- R3: For a data-input request (opcode 0x80) whose column is at least PAGE_BYTES (512), the pointer command is 0x50 and the column sent is the column minus 512.
- R4: For a data-input request whose column is below 256, or that has no column, the pointer command is 0x00 and the column is sent unchanged.
- R5: For a data-input request whose column is from 256 to 511, the pointer command is 0x01 and the column sent is the column minus 256.
- R6: The column is one address cycle carrying bits 7:0 of the (rebased) column. When `bus16_i` is 1, the column is shifted right by one first, unless the opcode is 0x90, 0xEC, 0xEE or 0xEF.
- R7: A page address gives row cycles carrying page bits 7:0, then bits 15:8. A third cycle carrying bits 23:16 follows only when `row3_i` is 1.
- R8: When `req_has_col_i` is 0, no column cycle is sent. When `req_has_page_i` is 0, no row cycles are sent. Nothing other than the listed steps is emitted.
- R9: One cycle after the release cycle is accepted, `wait_start_o` pulses for one cycle. It pulses only if the opcode is none of 0x10, 0x60, 0xD0, 0x80, 0x70, 0x90, 0xEF, and the request is not opcode 0x00 with neither address present. It is 0 at all other times.
- R10: While `cyc_valid_o` is 1 and `cyc_ready_i` is 0, the cycle byte and flags stay unchanged and `cyc_valid_o` stays 1.
- R11: `req_ready_o` is 0 from the cycle after a request is accepted until the release cycle has been accepted. `req_ready_o` and `cyc_valid_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| bus16_i | input | 1 | Device uses a 16-bit data bus |
| row3_i | input | 1 | Device takes three row address cycles |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted (sequencer idle) |
| req_op_i | input | 8 | Command opcode |
| req_col_i | input | COL_W | Column byte offset |
| req_has_col_i | input | 1 | Column present |
| req_page_i | input | 24 | Page (row) address |
| req_has_page_i | input | 1 | Page address present |
| cyc_valid_o | output | 1 | Bus cycle present |
| cyc_ready_i | input | 1 | Downstream takes the cycle |
| cyc_byte_o | output | 8 | Byte placed on the I/O bus |
| cyc_cle_o | output | 1 | Command latch enable |
| cyc_ale_o | output | 1 | Address latch enable |
| cyc_ce_o | output | 1 | Chip enable, 1 = selected |
| wait_start_o | output | 1 | One-cycle trigger for the wait engine |

## Verification
A wrong step mask at acceptance shows up at once as a missing or extra cycle. The release cycle then arrives at the wrong position in the stream, and the next request is accepted late or early. A wrong pointer or column rebase shows in the first one or three bytes of a data-input sequence. A wrong wait decision appears exactly one clock after the release handshake, so it never blurs into the next request. The bench applies random backpressure so that each stall exposes a step counter that advances without a handshake.

// File: rtl/spnand_pkg.sv
package spnand_pkg;

  localparam logic [7:0] OP_PTR_LOW   = 8'h00;
  localparam logic [7:0] OP_PTR_HIGH  = 8'h01;
  localparam logic [7:0] OP_PTR_SPARE = 8'h50;
  localparam logic [7:0] OP_DATA_IN   = 8'h80;
  localparam logic [7:0] OP_PROGRAM   = 8'h10;
  localparam logic [7:0] OP_ERASE_SET = 8'h60;
  localparam logic [7:0] OP_ERASE_GO  = 8'hD0;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_PARAMS    = 8'hEC;
  localparam logic [7:0] OP_FEAT_GET  = 8'hEE;
  localparam logic [7:0] OP_FEAT_SET  = 8'hEF;

  localparam int ROW_BITS  = 24;
  localparam int NUM_STEPS = 7;

  typedef enum logic [2:0] {
    ST_PTR  = 3'd0,
    ST_OP   = 3'd1,
    ST_COL  = 3'd2,
    ST_ROW0 = 3'd3,
    ST_ROW1 = 3'd4,
    ST_ROW2 = 3'd5,
    ST_END  = 3'd6
  } step_e;

  typedef struct packed {
    logic [7:0] data;
    logic       cle;
    logic       ale;
    logic       ce;
  } bus_cyc_t;

  // Opcodes whose address phase is always 8 bits wide.
  function automatic logic narrow_addr(logic [7:0] op);
    return (op == OP_IDENT) || (op == OP_PARAMS) ||
           (op == OP_FEAT_GET) || (op == OP_FEAT_SET);
  endfunction

  // Opcodes that leave busy handling to someone else.
  function automatic logic no_wait(logic [7:0] op, logic has_col, logic has_page);
    logic skip;
    skip = (op == OP_PROGRAM) || (op == OP_ERASE_SET) || (op == OP_ERASE_GO) ||
           (op == OP_DATA_IN) || (op == OP_STATUS) || (op == OP_IDENT) ||
           (op == OP_FEAT_SET);
    if (op == OP_PTR_LOW && !has_col && !has_page) skip = 1'b1;
    return skip;
  endfunction

  // Region pointer chosen by the column of a data-input request.
  function automatic logic [7:0] region_ptr(logic [15:0] col, logic [15:0] page_bytes,
                                            logic has_col);
    if (!has_col)               return OP_PTR_LOW;
    else if (col >= page_bytes) return OP_PTR_SPARE;
    else if (col < 16'd256)     return OP_PTR_LOW;
    else                        return OP_PTR_HIGH;
  endfunction

  // Column byte after region rebase and bus-width scaling.
  function automatic logic [7:0] col_byte(logic [15:0] col, logic [15:0] page_bytes,
                                          logic [7:0] op, logic wide_bus);
    logic [15:0] c;
    c = col;
    if (op == OP_DATA_IN) begin
      if (c >= page_bytes)     c = c - page_bytes;
      else if (c >= 16'd256)   c = c - 16'd256;
    end
    if (wide_bus && !narrow_addr(op)) c = c >> 1;
    return c[7:0];
  endfunction

  // Lowest enabled step at or after index 'from'.
  function automatic step_e first_from(logic [NUM_STEPS-1:0] m, int from);
    step_e r;
    logic  hit;
    r   = ST_END;
    hit = 1'b0;
    for (int i = 0; i < NUM_STEPS; i++) begin
      if (!hit && i >= from && m[i]) begin
        r   = step_e'(i);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/spnand_planner.sv
module spnand_planner
  import spnand_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int PAGE_BYTES = 512
) (
  input  logic [7:0]           op_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic                 has_col_i,
  input  logic                 has_page_i,
  input  logic                 bus16_i,
  input  logic                 row3_i,
  output logic [7:0]           ptr_o,
  output logic [7:0]           col_o,
  output logic [NUM_STEPS-1:0] mask_o,
  output logic                 need_wait_o
);
  localparam logic [15:0] PB16 = 16'(PAGE_BYTES);

  logic [15:0] col16;
  assign col16 = 16'(col_i);

  assign ptr_o       = region_ptr(col16, PB16, has_col_i);
  assign col_o       = col_byte(col16, PB16, op_i, bus16_i);
  assign need_wait_o = !no_wait(op_i, has_col_i, has_page_i);

  always_comb begin
    mask_o          = '0;
    mask_o[ST_PTR]  = (op_i == OP_DATA_IN);
    mask_o[ST_OP]   = 1'b1;
    mask_o[ST_COL]  = has_col_i;
    mask_o[ST_ROW0] = has_page_i;
    mask_o[ST_ROW1] = has_page_i;
    mask_o[ST_ROW2] = has_page_i && row3_i;
    mask_o[ST_END]  = 1'b1;
  end
endmodule

// File: rtl/spnand_stepper.sv
module spnand_stepper
  import spnand_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 start_i,
  input  logic [NUM_STEPS-1:0] mask_i,
  input  logic                 need_wait_i,
  input  logic                 take_i,
  output logic                 active_o,
  output step_e                step_o,
  output logic                 end_fire_o,
  output logic                 wait_pulse_o
);
  logic [NUM_STEPS-1:0] mask_q;
  logic                 need_q;

  assign end_fire_o = active_o && take_i && (step_o == ST_END);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      active_o     <= 1'b0;
      step_o       <= ST_END;
      mask_q       <= '0;
      need_q       <= 1'b0;
      wait_pulse_o <= 1'b0;
    end else begin
      wait_pulse_o <= 1'b0;
      if (!active_o && start_i) begin
        active_o <= 1'b1;
        mask_q   <= mask_i;
        need_q   <= need_wait_i;
        step_o   <= first_from(mask_i, 0);
      end else if (active_o && take_i) begin
        if (step_o == ST_END) begin
          active_o     <= 1'b0;
          wait_pulse_o <= need_q;
        end else begin
          step_o <= first_from(mask_q, int'(step_o) + 1);
        end
      end
    end
  end
endmodule

// File: rtl/spnand_cycle_mux.sv
module spnand_cycle_mux
  import spnand_pkg::*;
(
  input  step_e               step_i,
  input  logic [7:0]          ptr_i,
  input  logic [7:0]          op_i,
  input  logic [7:0]          col_i,
  input  logic [ROW_BITS-1:0] row_i,
  output bus_cyc_t            cyc_o
);
  always_comb begin
    unique case (step_i)
      ST_PTR:  cyc_o = '{data: ptr_i,         cle: 1'b1, ale: 1'b0, ce: 1'b1};
      ST_OP:   cyc_o = '{data: op_i,          cle: 1'b1, ale: 1'b0, ce: 1'b1};
      ST_COL:  cyc_o = '{data: col_i,         cle: 1'b0, ale: 1'b1, ce: 1'b1};
      ST_ROW0: cyc_o = '{data: row_i[7:0],    cle: 1'b0, ale: 1'b1, ce: 1'b1};
      ST_ROW1: cyc_o = '{data: row_i[15:8],   cle: 1'b0, ale: 1'b1, ce: 1'b1};
      ST_ROW2: cyc_o = '{data: row_i[23:16],  cle: 1'b0, ale: 1'b1, ce: 1'b1};
      default: cyc_o = '{data: 8'h00,         cle: 1'b0, ale: 1'b0, ce: 1'b0};
    endcase
  end
endmodule

// File: rtl/spnand_cmd_seq.sv
module spnand_cmd_seq
  import spnand_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int PAGE_BYTES = 512
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                bus16_i,
  input  logic                row3_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [7:0]          req_op_i,
  input  logic [COL_W-1:0]    req_col_i,
  input  logic                req_has_col_i,
  input  logic [ROW_BITS-1:0] req_page_i,
  input  logic                req_has_page_i,
  output logic                cyc_valid_o,
  input  logic                cyc_ready_i,
  output logic [7:0]          cyc_byte_o,
  output logic                cyc_cle_o,
  output logic                cyc_ale_o,
  output logic                cyc_ce_o,
  output logic                wait_start_o
);
  logic [7:0]           plan_ptr, plan_col;
  logic [NUM_STEPS-1:0] plan_mask;
  logic                 plan_wait;
  logic                 active, req_fire, end_fire;
  step_e                step;
  logic [7:0]           ptr_q, op_q, col_q;
  logic [ROW_BITS-1:0]  row_q;
  bus_cyc_t             cyc;

  spnand_planner #(.COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES)) u_plan (
    .op_i        (req_op_i),
    .col_i       (req_col_i),
    .has_col_i   (req_has_col_i),
    .has_page_i  (req_has_page_i),
    .bus16_i     (bus16_i),
    .row3_i      (row3_i),
    .ptr_o       (plan_ptr),
    .col_o       (plan_col),
    .mask_o      (plan_mask),
    .need_wait_o (plan_wait)
  );

  assign req_ready_o = !active;
  assign req_fire    = req_valid_i && !active;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ptr_q <= '0;
      op_q  <= '0;
      col_q <= '0;
      row_q <= '0;
    end else if (req_fire) begin
      ptr_q <= plan_ptr;
      op_q  <= req_op_i;
      col_q <= plan_col;
      row_q <= req_page_i;
    end
  end

  spnand_stepper u_step (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .start_i      (req_fire),
    .mask_i       (plan_mask),
    .need_wait_i  (plan_wait),
    .take_i       (cyc_ready_i),
    .active_o     (active),
    .step_o       (step),
    .end_fire_o   (end_fire),
    .wait_pulse_o (wait_start_o)
  );

  spnand_cycle_mux u_mux (
    .step_i (step),
    .ptr_i  (ptr_q),
    .op_i   (op_q),
    .col_i  (col_q),
    .row_i  (row_q),
    .cyc_o  (cyc)
  );

  assign cyc_valid_o = active;
  assign cyc_byte_o  = cyc.data;
  assign cyc_cle_o   = cyc.cle;
  assign cyc_ale_o   = cyc.ale;
  assign cyc_ce_o    = cyc.ce;
endmodule

// File: rtl/spnand_cmd_seq_chk.sv
module spnand_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_n_i,
  input logic       req_ready_o,
  input logic [7:0] req_op_i,
  input logic       req_fire,
  input logic       end_fire,
  input logic       cyc_valid_o,
  input logic       cyc_ready_i,
  input logic [7:0] cyc_byte_o,
  input logic       cyc_cle_o,
  input logic       cyc_ale_o,
  input logic       cyc_ce_o,
  input logic       wait_start_o
);
  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cyc_valid_o && !cyc_ready_i |=> cyc_valid_o && $stable(cyc_byte_o) &&
      $stable(cyc_cle_o) && $stable(cyc_ale_o) && $stable(cyc_ce_o));

  // R2
  latch_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cyc_valid_o |-> !(cyc_cle_o && cyc_ale_o));

  // R2
  release_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cyc_valid_o && !cyc_ce_o |-> !cyc_cle_o && !cyc_ale_o && cyc_byte_o == 8'h00);

  // R9
  wait_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wait_start_o |-> $past(end_fire));

  // R11
  busy_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(cyc_valid_o && req_ready_o));

  // R11
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    req_fire |=> !req_ready_o && cyc_valid_o);

  // R3
  ptr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    req_fire && req_op_i == 8'h80 |=> cyc_cle_o &&
      (cyc_byte_o == 8'h00 || cyc_byte_o == 8'h01 || cyc_byte_o == 8'h50));
endmodule

bind spnand_cmd_seq spnand_cmd_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .req_ready_o  (req_ready_o),
  .req_op_i     (req_op_i),
  .req_fire     (req_fire),
  .end_fire     (end_fire),
  .cyc_valid_o  (cyc_valid_o),
  .cyc_ready_i  (cyc_ready_i),
  .cyc_byte_o   (cyc_byte_o),
  .cyc_cle_o    (cyc_cle_o),
  .cyc_ale_o    (cyc_ale_o),
  .cyc_ce_o     (cyc_ce_o),
  .wait_start_o (wait_start_o)
);

// File: tb/tb_spnand_cmd_seq.sv
`timescale 1ns/1ps
module tb_spnand_cmd_seq;
  localparam int COL_W = 10;

  logic        clk_i = 1'b0, rst_n_i = 1'b0;
  logic        bus16_i = 1'b0, row3_i = 1'b0;
  logic        req_valid_i = 1'b0, req_ready_o;
  logic [7:0]  req_op_i = '0;
  logic [COL_W-1:0] req_col_i = '0;
  logic        req_has_col_i = 1'b0, req_has_page_i = 1'b0;
  logic [23:0] req_page_i = '0;
  logic        cyc_valid_o, cyc_ready_i = 1'b0;
  logic [7:0]  cyc_byte_o;
  logic        cyc_cle_o, cyc_ale_o, cyc_ce_o, wait_start_o;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  spnand_cmd_seq #(.COL_W(COL_W), .PAGE_BYTES(512)) dut (.*);

  // expected stream
  logic [7:0] e_byte [8];
  logic [2:0] e_flag [8];
  string      e_tag  [8];
  int         e_n;
  bit         e_wait;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic void push(input logic [7:0] b, input logic [2:0] f, input string t);
    e_byte[e_n] = b; e_flag[e_n] = f; e_tag[e_n] = t; e_n++;
  endfunction

  // flags packed as {cle, ale, ce}
  function automatic void model(input logic [7:0] op, input int col, input bit hc,
                                input int page, input bit hp, input bit b16, input bit r3);
    int c;
    bit narrow;
    e_n = 0;
    c = col;
    if (op == 8'h80) begin
      if (hc && col >= 512)      begin push(8'h50, 3'b101, "R3"); c = col - 512; end
      else if (hc && col >= 256) begin push(8'h01, 3'b101, "R5"); c = col - 256; end
      else                            push(8'h00, 3'b101, "R4");
    end
    push(op, 3'b101, "R2");
    narrow = (op == 8'h90 || op == 8'hEC || op == 8'hEE || op == 8'hEF);
    if (hc) push(8'((b16 && !narrow) ? c / 2 : c), 3'b011, "R6");
    if (hp) begin
      push(8'(page), 3'b011, "R7");
      push(8'(page >> 8), 3'b011, "R7");
      if (r3) push(8'(page >> 16), 3'b011, "R7");
    end
    push(8'h00, 3'b000, "R2");
    case (op)
      8'h10, 8'h60, 8'hD0, 8'h80, 8'h70, 8'h90, 8'hEF: e_wait = 1'b0;
      8'h00:   e_wait = hc || hp;
      default: e_wait = 1'b1;
    endcase
  endfunction

  task automatic run_req(input logic [7:0] op, input int col, input bit hc,
                         input int page, input bit hp, input bit b16, input bit r3,
                         input int stall_pct);
    int idx, guard;
    bit hold;
    logic [10:0] held;
    model(op, col, hc, page, hp, b16, r3);
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R11", "idle ready", int'(req_ready_o), 1);
    bus16_i = b16; row3_i = r3;
    req_op_i = op; req_col_i = COL_W'(col); req_has_col_i = hc;
    req_page_i = 24'(page); req_has_page_i = hp; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R11", "busy after accept", int'(req_ready_o), 0);
    idx = 0; guard = 0; hold = 1'b0; held = '0;
    while (idx < e_n && guard < 200) begin
      guard++;
      if (hold)
        chk(cyc_valid_o && {cyc_byte_o, cyc_cle_o, cyc_ale_o, cyc_ce_o} == held,
            "R10", "stalled cycle held",
            int'({cyc_byte_o, cyc_cle_o, cyc_ale_o, cyc_ce_o}), int'(held));
      if (wait_start_o) chk(1'b0, "R9", "trigger during sequence", 1, 0);
      cyc_ready_i = ($urandom % 100) >= stall_pct;
      if (cyc_valid_o) begin
        if (cyc_ready_i) begin
          chk(cyc_byte_o == e_byte[idx], e_tag[idx], "cycle byte",
              int'(cyc_byte_o), int'(e_byte[idx]));
          chk({cyc_cle_o, cyc_ale_o, cyc_ce_o} == e_flag[idx], e_tag[idx], "cycle flags",
              int'({cyc_cle_o, cyc_ale_o, cyc_ce_o}), int'(e_flag[idx]));
          idx++;
          hold = 1'b0;
        end else begin
          hold = 1'b1;
          held = {cyc_byte_o, cyc_cle_o, cyc_ale_o, cyc_ce_o};
        end
      end
      @(negedge clk_i);
    end
    cyc_ready_i = 1'b0;
    chk(idx == e_n, "R8", "cycle count", idx, e_n);
    chk(cyc_valid_o == 1'b0, "R8", "no cycle after release", int'(cyc_valid_o), 0);
    chk(wait_start_o == e_wait, "R9", "wait trigger", int'(wait_start_o), int'(e_wait));
    chk(req_ready_o == 1'b1, "R11", "ready after release", int'(req_ready_o), 1);
    @(negedge clk_i);
    chk(wait_start_o == 1'b0, "R9", "trigger one cycle", int'(wait_start_o), 0);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [14];
    ops = '{8'h00, 8'h01, 8'h50, 8'h80, 8'h10, 8'h60, 8'hD0,
            8'h70, 8'h90, 8'hEF, 8'hEE, 8'hEC, 8'hFF, 8'h30};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1", "reset ready", int'(req_ready_o), 1);
    chk(cyc_valid_o == 1'b0, "R1", "reset valid", int'(cyc_valid_o), 0);
    chk(wait_start_o == 1'b0, "R1", "reset trigger", int'(wait_start_o), 0);
    rst_n_i = 1'b1;

    // directed corners: R3 R4 R5 region boundaries
    run_req(8'h80, 0,   1, 24'h001234, 1, 0, 0, 0);
    run_req(8'h80, 255, 1, 24'h00ABCD, 1, 0, 1, 30);
    run_req(8'h80, 256, 1, 24'h123456, 1, 0, 1, 30);
    run_req(8'h80, 511, 1, 24'h000001, 1, 0, 0, 50);
    run_req(8'h80, 512, 1, 24'h000002, 1, 0, 0, 50);
    run_req(8'h80, 527, 1, 24'h000003, 1, 1, 1, 20);
    run_req(8'h80, 0,   0, 24'h000004, 1, 0, 0, 0);
    // R6 bus width and narrow-address opcodes
    run_req(8'h00, 510, 1, 24'h00FF00, 1, 1, 0, 0);
    run_req(8'h90, 8'h40, 1, 0, 0, 1, 0, 0);
    run_req(8'hEF, 8'h81, 1, 0, 0, 1, 0, 40);
    // R8 R9 address suppression and wait decisions
    run_req(8'h00, 0, 0, 0, 0, 0, 0, 0);
    run_req(8'h00, 0, 0, 24'h000010, 1, 0, 1, 0);
    run_req(8'h70, 0, 0, 0, 0, 0, 0, 0);
    run_req(8'h60, 0, 0, 24'hFEDCBA, 1, 0, 1, 0);
    run_req(8'hFF, 0, 0, 0, 0, 0, 0, 60);
    run_req(8'h10, 0, 0, 0, 0, 0, 0, 0);

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      int col;
      col = ($urandom % 4 == 0) ? int'($urandom % 1024) : int'($urandom % 528);
      run_req(ops[$urandom % 14], col, $urandom % 4 != 0, int'($urandom % 24'hFFFFFF + 1),
              $urandom % 3 != 0, $urandom % 2 == 1, $urandom % 2 == 1,
              int'($urandom % 70));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule